// File: doc/BRIEF.md
# Frame Data-Type Filter and Line-Count Checker

This block sits behind a camera packet decoder. Each cycle it may receive one payload word tagged with a 6-bit data type, plus single-cycle frame-start, frame-end and line-end markers. A payload word goes downstream only when its data type lies inside an inclusive window set by two configuration inputs. Every other word is dropped. Forwarded words leave one cycle later. A swap mode can reverse their byte order.

The block also counts the lines of each frame. When the stream carries line-end markers, each marker ends a line. When it does not, a line ends once the programmed number of forwarded words has arrived. At frame end the count is compared with the programmed line count. Three sticky raw status bits record the result: too few lines, too many lines, and a frame forwarded incomplete. Each raw bit is cleared by writing 1 to its clear input. A per-bit enable masks the raw bits into a status vector and an interrupt line.

The suggested configuration after reset is a window of 24 to 47, 480 lines of 480 words, line-end markers present, the check turned off and normal byte order. These values are collected in the package.

Top module: `frame_dt_filter`

## Requirements
- R1: A word with inValid=1 is forwarded only when cfgTypeMin <= inDataType <= cfgTypeMax, with both limits included. A forwarded word appears on outValid/outData on the clock edge after the one that sampled it. Any other word leaves outValid low.
- R2: With cfgSwapBytes=1, byte k of outData (bits 8k+7:8k) equals byte N-1-k of the input word, where N is the number of bytes in a word. With cfgSwapBytes=0 the word is passed unchanged.
- R3: With cfgHasLineSync=1, each inLineEnd pulse adds one line to the count, and inFrameStart resets the count to zero.
- R4: With cfgHasLineSync=0, a line ends when the number of forwarded words since the last line end or frame start reaches cfgPixels. Dropped words do not count, and inLineEnd is ignored.
- R5: On inFrameEnd with cfgCheckEn=1, a line count below cfgLines sets rawStatus[0] (programmed count greater than real).
- R6: On inFrameEnd with cfgCheckEn=1, a line count above cfgLines sets rawStatus[1] (programmed count smaller than real).
- R7: With cfgCheckEn=0, a frame end never sets rawStatus[0] or rawStatus[1].
- R8: On inFrameEnd, a line count below cfgLines sets rawStatus[2] (incomplete frame) whatever the value of cfgCheckEn. A count equal to cfgLines sets no status bit.
- R9: Raw bits are sticky. intClear[i]=1 clears rawStatus[i] on the next edge, and in the same cycle a set takes priority over a clear. A raw bit rises only on the edge that samples inFrameEnd.
- R10: maskedStatus equals rawStatus AND intEnable, and irq is the OR of maskedStatus.
- R11: After reset, outValid, rawStatus, maskedStatus and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Payload word present |
| inDataType | input | 6 | Data type of the payload word |
| inData | input | 32 | Payload word |
| inFrameStart | input | 1 | Frame-start marker pulse |
| inFrameEnd | input | 1 | Frame-end marker pulse |
| inLineEnd | input | 1 | Line-end marker pulse |
| cfgTypeMin | input | 6 | Lower bound of the data-type window (inclusive) |
| cfgTypeMax | input | 6 | Upper bound of the data-type window (inclusive) |
| cfgLines | input | 12 | Expected lines per frame |
| cfgPixels | input | 12 | Words per line when no line-end markers are present |
| cfgHasLineSync | input | 1 | 1: line-end markers present |
| cfgCheckEn | input | 1 | Enable the line-count comparison |
| cfgSwapBytes | input | 1 | Reverse byte order of forwarded words |
| intEnable | input | 3 | Per-bit status enable |
| intClear | input | 3 | Per-bit write-1-to-clear |
| outValid | output | 1 | Forwarded word present |
| outData | output | 32 | Forwarded word |
| rawStatus | output | 3 | Sticky raw status: [0] too few, [1] too many, [2] incomplete |
| maskedStatus | output | 3 | rawStatus AND intEnable |
| irq | output | 1 | OR of maskedStatus |

## Verification
The window filter is tested with data types just below, at, inside and just above both limits, which separates an inclusive comparison from an exclusive or off-by-one one. Frames are sent with exactly, fewer and more lines than programmed, with the check both on and off. This separates the two count-mismatch bits from each other and from the incomplete flag, which does not depend on the check enable. In the mode without line markers, the frames mix in dropped words and stray line-end pulses to show that neither one advances the count. Status tests apply partial clears and partial enables, and send a frame end in the same cycle as a clear, so that set priority is visible.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam int DT_W  = 6;
  localparam int CNT_W = 12;
  localparam int ST_W  = 3;

  localparam logic [DT_W-1:0]  DEF_TYPE_MIN = 6'd24;
  localparam logic [DT_W-1:0]  DEF_TYPE_MAX = 6'd47;
  localparam logic [CNT_W-1:0] DEF_LINES    = 12'd480;
  localparam logic [CNT_W-1:0] DEF_PIXELS   = 12'd480;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic swap;
  } dpStrobe_t;

  // frame-end events, packed so bit 0 = few, bit 1 = many, bit 2 = incomplete
  typedef struct packed {
    logic incomplete;
    logic many;
    logic few;
  } statEvt_t;
endpackage

// File: rtl/fdf_ctrl.sv
module fdf_ctrl
  import fdf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [DT_W-1:0]  inDataType,
  input  logic             inFrameStart,
  input  logic             inFrameEnd,
  input  logic             inLineEnd,
  input  logic [DT_W-1:0]  cfgTypeMin,
  input  logic [DT_W-1:0]  cfgTypeMax,
  input  logic [CNT_W-1:0] cfgLines,
  input  logic [CNT_W-1:0] cfgPixels,
  input  logic             cfgHasLineSync,
  input  logic             cfgCheckEn,
  input  logic             cfgSwapBytes,
  output dpStrobe_t        dpCtl,
  output statEvt_t         events
);
  logic [CNT_W-1:0] lineCount;
  logic [CNT_W-1:0] pixCount;
  logic             passNow;
  logic             pixLineDone;
  logic             lineDone;
  logic [CNT_W:0]   finalCount;
  logic             isFew;
  logic             isMany;

  assign passNow     = inValid && (inDataType >= cfgTypeMin) && (inDataType <= cfgTypeMax);
  assign pixLineDone = !cfgHasLineSync && passNow &&
                       (({1'b0, pixCount} + 1'b1) >= {1'b0, cfgPixels});
  assign lineDone    = cfgHasLineSync ? inLineEnd : pixLineDone;

  // a line that closes in the frame-end cycle still counts
  assign finalCount  = {1'b0, lineCount} + {{CNT_W{1'b0}}, lineDone};
  assign isFew       = finalCount < {1'b0, cfgLines};
  assign isMany      = finalCount > {1'b0, cfgLines};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCount <= '0;
      pixCount  <= '0;
    end else if (inFrameStart) begin
      lineCount <= '0;
      pixCount  <= '0;
    end else begin
      if (lineDone) lineCount <= lineCount + 1'b1;
      if (pixLineDone)
        pixCount <= '0;
      else if (passNow && !cfgHasLineSync)
        pixCount <= pixCount + 1'b1;
    end
  end

  always_comb begin
    dpCtl.load        = passNow;
    dpCtl.swap        = cfgSwapBytes;
    events.few        = inFrameEnd && cfgCheckEn && isFew;
    events.many       = inFrameEnd && cfgCheckEn && isMany;
    events.incomplete = inFrameEnd && isFew;
  end
endmodule

// File: rtl/fdf_datapath.sv
module fdf_datapath
  import fdf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpCtl,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] swapped;

  genvar gb;
  generate
    for (gb = 0; gb < NBYTES; gb++) begin : g_swap
      assign swapped[gb*8 +: 8] = inData[(NBYTES-1-gb)*8 +: 8];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= dpCtl.load;
      if (dpCtl.load) outData <= dpCtl.swap ? swapped : inData;
    end
  end
endmodule

// File: rtl/fdf_status.sv
module fdf_status
  import fdf_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  statEvt_t        events,
  input  logic [ST_W-1:0] intEnable,
  input  logic [ST_W-1:0] intClear,
  output logic [ST_W-1:0] rawStatus,
  output logic [ST_W-1:0] maskedStatus,
  output logic            irq
);
  logic [ST_W-1:0] setVec;
  assign setVec = events;

  always_ff @(posedge clk) begin
    if (!rstN) rawStatus <= '0;
    else       rawStatus <= (rawStatus & ~intClear) | setVec;
  end

  assign maskedStatus = rawStatus & intEnable;
  assign irq          = |maskedStatus;
endmodule

// File: rtl/frame_dt_filter.sv
module frame_dt_filter
  import fdf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [5:0]        inDataType,
  input  logic [DATA_W-1:0] inData,
  input  logic              inFrameStart,
  input  logic              inFrameEnd,
  input  logic              inLineEnd,
  input  logic [5:0]        cfgTypeMin,
  input  logic [5:0]        cfgTypeMax,
  input  logic [11:0]       cfgLines,
  input  logic [11:0]       cfgPixels,
  input  logic              cfgHasLineSync,
  input  logic              cfgCheckEn,
  input  logic              cfgSwapBytes,
  input  logic [2:0]        intEnable,
  input  logic [2:0]        intClear,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [2:0]        rawStatus,
  output logic [2:0]        maskedStatus,
  output logic              irq
);
  dpStrobe_t dpCtl;
  statEvt_t  events;

  fdf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDataType(inDataType),
    .inFrameStart(inFrameStart), .inFrameEnd(inFrameEnd), .inLineEnd(inLineEnd),
    .cfgTypeMin(cfgTypeMin), .cfgTypeMax(cfgTypeMax), .cfgLines(cfgLines),
    .cfgPixels(cfgPixels), .cfgHasLineSync(cfgHasLineSync), .cfgCheckEn(cfgCheckEn),
    .cfgSwapBytes(cfgSwapBytes), .dpCtl(dpCtl), .events(events)
  );

  fdf_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .inData(inData),
    .outValid(outValid), .outData(outData)
  );

  fdf_status u_stat (
    .clk(clk), .rstN(rstN), .events(events), .intEnable(intEnable),
    .intClear(intClear), .rawStatus(rawStatus), .maskedStatus(maskedStatus), .irq(irq)
  );
endmodule

// File: rtl/fdf_checker.sv
module fdf_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [5:0]        inDataType,
  input logic [DATA_W-1:0] inData,
  input logic              inFrameEnd,
  input logic [5:0]        cfgTypeMin,
  input logic [5:0]        cfgTypeMax,
  input logic              cfgCheckEn,
  input logic              cfgSwapBytes,
  input logic [2:0]        intClear,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic [2:0]        rawStatus,
  input logic              irq
);
  AST_PASS_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ($past(inValid) && $past(inDataType) >= $past(cfgTypeMin)
                  && $past(inDataType) <= $past(cfgTypeMax)));  // R1

  AST_SWAP_LOW_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(cfgSwapBytes)) |-> outData[7:0] == $past(inData[DATA_W-1 -: 8]));  // R2

  AST_NO_SWAP_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !$past(cfgSwapBytes)) |-> outData == $past(inData));  // R2

  AST_MANY_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawStatus[1]) |-> $past(cfgCheckEn));  // R7

  AST_FEW_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rawStatus[0]) |-> $past(cfgCheckEn));  // R7

  AST_FEW_MANY_APART: assert property (@(posedge clk) disable iff (!rstN)
    !($rose(rawStatus[0]) && $rose(rawStatus[1])));  // R5

  AST_RAW_RISE_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    ((rawStatus & ~$past(rawStatus)) != 3'b000) |-> $past(inFrameEnd));  // R9

  AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (($past(rawStatus) & ~$past(intClear) & ~rawStatus) == 3'b000));  // R9

  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (rawStatus != 3'b000));  // R10
endmodule

bind frame_dt_filter fdf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inDataType(inDataType), .inData(inData),
  .inFrameEnd(inFrameEnd), .cfgTypeMin(cfgTypeMin), .cfgTypeMax(cfgTypeMax),
  .cfgCheckEn(cfgCheckEn), .cfgSwapBytes(cfgSwapBytes), .intClear(intClear),
  .outValid(outValid), .outData(outData), .rawStatus(rawStatus), .irq(irq)
);

// File: tb/tb_frame_dt_filter.sv
module tb_frame_dt_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [5:0]  inDataType = '0;
  logic [31:0] inData = '0;
  logic        inFrameStart = 1'b0, inFrameEnd = 1'b0, inLineEnd = 1'b0;
  logic [5:0]  cfgTypeMin = 6'd24, cfgTypeMax = 6'd47;
  logic [11:0] cfgLines = 12'd480, cfgPixels = 12'd480;
  logic        cfgHasLineSync = 1'b1, cfgCheckEn = 1'b0, cfgSwapBytes = 1'b0;
  logic [2:0]  intEnable = '0, intClear = '0;
  logic        outValid;
  logic [31:0] outData;
  logic [2:0]  rawStatus, maskedStatus;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  frame_dt_filter dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDataType(inDataType), .inData(inData),
    .inFrameStart(inFrameStart), .inFrameEnd(inFrameEnd), .inLineEnd(inLineEnd),
    .cfgTypeMin(cfgTypeMin), .cfgTypeMax(cfgTypeMax), .cfgLines(cfgLines),
    .cfgPixels(cfgPixels), .cfgHasLineSync(cfgHasLineSync), .cfgCheckEn(cfgCheckEn),
    .cfgSwapBytes(cfgSwapBytes), .intEnable(intEnable), .intClear(intClear),
    .outValid(outValid), .outData(outData), .rawStatus(rawStatus),
    .maskedStatus(maskedStatus), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] revBytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // drive one word at a falling edge; result visible at the next falling edge
  task automatic sendWord(input logic [5:0] dt, input logic [31:0] d);
    inValid = 1'b1; inDataType = dt; inData = d;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic syncPulse(input logic fs, input logic le, input logic fe);
    inFrameStart = fs; inLineEnd = le; inFrameEnd = fe;
    @(negedge clk);
    inFrameStart = 1'b0; inLineEnd = 1'b0; inFrameEnd = 1'b0;
  endtask

  task automatic clearAll();
    intClear = 3'b111;
    @(negedge clk);
    intClear = 3'b000;
  endtask

  task automatic syncFrame(input int lines);
    syncPulse(1, 0, 0);
    for (int i = 0; i < lines; i++) begin
      sendWord(6'd30, 32'(i));
      syncPulse(0, 1, 0);
    end
    syncPulse(0, 0, 1);
  endtask

  task automatic testReset();
    check("R11 outValid", {31'b0, outValid}, 32'd0);
    check("R11 rawStatus", {29'b0, rawStatus}, 32'd0);
    check("R11 irq", {31'b0, irq}, 32'd0);
  endtask

  task automatic testWindow();
    sendWord(6'd23, 32'hAAAA0001); check("R1 below min dropped", {31'b0, outValid}, 0);
    sendWord(6'd24, 32'hAAAA0002); check("R1 at min valid", {31'b0, outValid}, 1);
    check("R1 at min data", outData, 32'hAAAA0002);
    sendWord(6'd47, 32'hAAAA0003); check("R1 at max data", outData, 32'hAAAA0003);
    check("R1 at max valid", {31'b0, outValid}, 1);
    sendWord(6'd48, 32'hAAAA0004); check("R1 above max dropped", {31'b0, outValid}, 0);
    sendWord(6'd35, 32'hAAAA0005); check("R1 inside data", outData, 32'hAAAA0005);
    @(negedge clk); check("R1 idle low", {31'b0, outValid}, 0);
  endtask

  task automatic testSwap();
    cfgSwapBytes = 1'b1;
    sendWord(6'd30, 32'h11223344); check("R2 swapped", outData, revBytes(32'h11223344));
    sendWord(6'd30, 32'hA1B2C3D4); check("R2 swapped 2", outData, 32'hD4C3B2A1);
    cfgSwapBytes = 1'b0;
    sendWord(6'd30, 32'h11223344); check("R2 normal", outData, 32'h11223344);
  endtask

  task automatic testSyncCount();
    cfgHasLineSync = 1'b1; cfgLines = 12'd3; cfgCheckEn = 1'b1;
    syncFrame(3); check("R3/R8 exact count no status", {29'b0, rawStatus}, 32'h0);
    syncFrame(2); check("R5/R8 too few", {29'b0, rawStatus}, 32'h5);
    clearAll();   check("R9 clear all", {29'b0, rawStatus}, 32'h0);
    syncFrame(4); check("R6 too many", {29'b0, rawStatus}, 32'h2);
    clearAll();
    // frame start must reset the count: leftover lines before FS
    syncPulse(0, 1, 0); syncPulse(0, 1, 0);
    syncFrame(3); check("R3 frame start resets count", {29'b0, rawStatus}, 32'h0);
    cfgCheckEn = 1'b0;
    syncFrame(2); check("R7/R8 check off only incomplete", {29'b0, rawStatus}, 32'h4);
    syncFrame(5); check("R7 check off no many", {29'b0, rawStatus}, 32'h4);
    clearAll();
  endtask

  task automatic testPixelLines();
    cfgHasLineSync = 1'b0; cfgPixels = 12'd4; cfgLines = 12'd2; cfgCheckEn = 1'b1;
    syncPulse(1, 0, 0);
    for (int i = 0; i < 8; i++) begin
      sendWord(6'd40, 32'(i));
      sendWord(6'd50, 32'(i));   // dropped, must not count
      syncPulse(0, 1, 0);        // ignored in this mode
    end
    syncPulse(0, 0, 1);
    check("R4 eight words two lines", {29'b0, rawStatus}, 32'h0);
    syncPulse(1, 0, 0);
    for (int i = 0; i < 7; i++) sendWord(6'd40, 32'(i));
    syncPulse(0, 0, 1);
    check("R4 seven words one line", {29'b0, rawStatus}, 32'h5);
  endtask

  task automatic testMask();
    intEnable = 3'b001; #1;
    check("R10 masked few", {29'b0, maskedStatus}, 32'h1);
    check("R10 irq on", {31'b0, irq}, 1);
    intEnable = 3'b010; #1;
    check("R10 masked none", {29'b0, maskedStatus}, 32'h0);
    check("R10 irq off", {31'b0, irq}, 0);
    intEnable = 3'b000;
    intClear = 3'b001; @(negedge clk); intClear = 3'b000;
    check("R9 partial clear", {29'b0, rawStatus}, 32'h4);
    clearAll();
  endtask

  task automatic testSetWins();
    cfgHasLineSync = 1'b1; cfgLines = 12'd3; cfgCheckEn = 1'b1;
    syncPulse(1, 0, 0);
    syncPulse(0, 1, 0);
    intClear = 3'b111;
    syncPulse(0, 0, 1);
    intClear = 3'b000;
    check("R9 set wins over clear", {29'b0, rawStatus}, 32'h5);
    @(negedge clk);
    check("R9 sticky hold", {29'b0, rawStatus}, 32'h5);
    clearAll();
  endtask

  initial begin
    #(20 * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWindow();
    testSwap();
    testSyncCount();
    testPixelLines();
    testMask();
    testSetWins();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule